// File: doc/BRIEF.md
# Indirect Parameter Memory Window

This block lets a narrow host register port reach a 512-word store of 12-bit parameters that sits behind a slower request/acknowledge memory port. The host never addresses the store directly. It loads a read pointer or a write pointer, then touches a single data register. A data write queues one word for the store at the write pointer and steps that pointer. A data read returns the word already fetched into a holding buffer, steps the read pointer, and starts fetching the following word.

Loading the read pointer starts a fetch at once, so the first data read finds its word waiting. The status register shows what is still in flight. The host polls it until busy clears before its next data access. A data access made while busy is dropped and leaves a sticky error bit. Reading the status register clears that bit.

Top module: `pmem_window`

## Requirements
- R1: After reset the status register reads 0, `mem_req` is low and the data register reads 0.
- R2: A host write to offset 1 loads the read pointer from `hst_wdata[8:0]` and ignores bits [15:9]. It starts a fetch of that word, and once the read-pending flag clears, the data register holds the stored word.
- R3: A host read of offset 3 returns the buffered word in bits [11:0] with bits [15:12] zero. It advances the read pointer by one and fetches the word at the new pointer.
- R4: A host write to offset 2 loads the write pointer from `hst_wdata[8:0]`. A host write to offset 3 stores `hst_wdata[11:0]` at the write pointer and advances the pointer by one.
- R5: Both pointers wrap from 511 to 0 when advanced.
- R6: A host read of offset 0 returns the status word: bit 0 is write pending, bit 1 is read pending, bit 2 is busy (either pending), bit 3 is error, and the other bits are zero.
- R7: `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` stable until `mem_ack` is sampled. It drops in the following cycle, and only one transfer is outstanding at a time.
- R8: A data read or write at offset 3 made while busy has no effect on the store or on either pointer, and it sets the error bit. A status read clears the error bit.
- R9: A read-pointer load accepted while a data write is still in flight is served after that write completes, so fetching the address just written returns the new word.
- R10: A read-pointer load while a fetch is in flight, including in the cycle its acknowledge arrives, discards that fetch's word and fetches the newly loaded address instead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_addr | input | 2 | Register offset: 0 status, 1 read pointer, 2 write pointer, 3 data |
| hst_wr | input | 1 | Host write strobe, one cycle per access |
| hst_wdata | input | 16 | Host write data |
| hst_rd | input | 1 | Host read strobe, one cycle per access |
| hst_rdata | output | 16 | Read data for the addressed register while `hst_rd` is high |
| mem_req | output | 1 | Store access request, held until acknowledged |
| mem_we | output | 1 | 1 for a store write, 0 for a fetch |
| mem_addr | output | 9 | Store word address |
| mem_wdata | output | 12 | Word to store |
| mem_ack | input | 1 | Store acknowledge, one cycle |
| mem_rdata | input | 12 | Fetched word, valid with `mem_ack` |

## Verification
Two things can land in the same clock cycle: a host read-pointer load and the store's acknowledge of the fetch that load replaces. The bench waits for the acknowledge to appear, then drives the pointer write in that very cycle. It judges the result by the word the data register returns afterwards, which must come from the new address. A second overlap, a pointer load while a data write is in flight, is judged by reading back the word just written.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_RPTR = 2'd1,
    REG_WPTR = 2'd2,
    REG_DATA = 2'd3
  } pmw_reg_e;

  localparam int ST_WPEND = 0;
  localparam int ST_RPEND = 1;
  localparam int ST_BUSY  = 2;
  localparam int ST_ERR   = 3;
  localparam int ST_BITS  = 4;
endpackage

// File: rtl/pmw_rstsync.sv
module pmw_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_n;

  always_comb begin
    sync_n = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_n;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/pmw_regif.sv
module pmw_regif
  import pmw_pkg::*;
#(
  parameter int AW = 9,
  parameter int DW = 12,
  parameter int HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    hst_addr,
  input  logic          hst_wr,
  input  logic [HW-1:0] hst_wdata,
  input  logic          hst_rd,
  output logic [HW-1:0] hst_rdata,
  input  logic          rd_pend,
  input  logic          wr_pend,
  input  logic [DW-1:0] rd_buf,
  output logic          rd_kick,
  output logic [AW-1:0] rd_kick_addr,
  output logic          wr_kick,
  output logic [AW-1:0] wr_kick_addr,
  output logic [DW-1:0] wr_kick_data
);
  localparam int PADD = HW - DW;
  localparam int PADS = HW - ST_BITS;

  logic [AW-1:0] rptr_q, rptr_n;
  logic [AW-1:0] wptr_q, wptr_n;
  logic          err_q, err_n;
  logic          busy;
  logic          acc_wr, acc_rd;
  logic          data_wr, data_rd;
  pmw_reg_e      sel;
  logic          unused_hi;

  assign unused_hi = ^hst_wdata[HW-1:DW];
  assign busy      = rd_pend | wr_pend;

  always_comb begin
    sel     = pmw_reg_e'(hst_addr);
    acc_wr  = hst_wr;
    acc_rd  = hst_rd & ~hst_wr;
    data_wr = acc_wr && (sel == REG_DATA);
    data_rd = acc_rd && (sel == REG_DATA);

    rptr_n       = rptr_q;
    wptr_n       = wptr_q;
    err_n        = err_q;
    rd_kick      = 1'b0;
    rd_kick_addr = rptr_q;
    wr_kick      = 1'b0;
    wr_kick_addr = wptr_q;
    wr_kick_data = hst_wdata[DW-1:0];

    if (acc_wr && (sel == REG_RPTR)) begin
      rptr_n       = hst_wdata[AW-1:0];
      rd_kick      = 1'b1;
      rd_kick_addr = hst_wdata[AW-1:0];
    end
    if (acc_wr && (sel == REG_WPTR)) begin
      wptr_n = hst_wdata[AW-1:0];
    end
    if (data_wr) begin
      if (busy) begin
        err_n = 1'b1;
      end else begin
        wr_kick = 1'b1;
        wptr_n  = wptr_q + 1'b1;
      end
    end
    if (data_rd) begin
      if (busy) begin
        err_n = 1'b1;
      end else begin
        rptr_n       = rptr_q + 1'b1;
        rd_kick      = 1'b1;
        rd_kick_addr = rptr_n;
      end
    end
    if (acc_rd && (sel == REG_STAT)) begin
      err_n = 1'b0;
    end
  end

  always_comb begin
    hst_rdata = '0;
    if (hst_rd) begin
      case (sel)
        REG_STAT: hst_rdata = {{PADS{1'b0}}, err_q, busy, rd_pend, wr_pend};
        REG_DATA: hst_rdata = {{PADD{1'b0}}, rd_buf};
        default:  hst_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      wptr_q <= '0;
      err_q  <= 1'b0;
    end else begin
      rptr_q <= rptr_n;
      wptr_q <= wptr_n;
      err_q  <= err_n;
    end
  end

  // R8: a data access while busy must leave the error bit set
  p_err_on_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_wr || data_rd) && busy) |=> err_q);

  // R8: a refused data write must not move the write pointer
  p_wptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && busy) |=> $stable(wptr_q));

  // R4: an accepted data write steps the write pointer by one
  p_wptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !busy) |=> (wptr_q == AW'($past(wptr_q) + 1'b1)));
endmodule

// File: rtl/pmw_xfer.sv
module pmw_xfer #(
  parameter int AW = 9,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_kick,
  input  logic [AW-1:0] rd_kick_addr,
  input  logic          wr_kick,
  input  logic [AW-1:0] wr_kick_addr,
  input  logic [DW-1:0] wr_kick_data,
  output logic          rd_pend,
  output logic          wr_pend,
  output logic [DW-1:0] rd_buf,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  logic          rpend_q, rpend_n;
  logic [AW-1:0] raddr_q, raddr_n;
  logic          stale_q, stale_n;
  logic          wpend_q, wpend_n;
  logic [AW-1:0] waddr_q, waddr_n;
  logic [DW-1:0] wdata_q, wdata_n;
  logic          req_q, req_n;
  logic          we_q, we_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] buf_q, buf_n;
  logic          ack;

  always_comb begin
    ack     = req_q & mem_ack;
    rpend_n = rpend_q;
    raddr_n = raddr_q;
    stale_n = stale_q;
    wpend_n = wpend_q;
    waddr_n = waddr_q;
    wdata_n = wdata_q;
    req_n   = req_q;
    we_n    = we_q;
    addr_n  = addr_q;
    buf_n   = buf_q;

    if (ack) begin
      req_n = 1'b0;
      if (we_q) begin
        wpend_n = 1'b0;
      end else begin
        stale_n = 1'b0;
        if (!stale_q && !rd_kick) begin
          buf_n   = mem_rdata;
          rpend_n = 1'b0;
        end
      end
    end

    if (wr_kick) begin
      wpend_n = 1'b1;
      waddr_n = wr_kick_addr;
      wdata_n = wr_kick_data;
    end

    if (rd_kick) begin
      rpend_n = 1'b1;
      raddr_n = rd_kick_addr;
      if (req_q && !we_q && !ack) stale_n = 1'b1;
    end

    if (!req_q) begin
      if (wpend_n) begin
        req_n  = 1'b1;
        we_n   = 1'b1;
        addr_n = waddr_n;
      end else if (rpend_n) begin
        req_n  = 1'b1;
        we_n   = 1'b0;
        addr_n = raddr_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpend_q <= 1'b0;
      raddr_q <= '0;
      stale_q <= 1'b0;
      wpend_q <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
      req_q   <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      buf_q   <= '0;
    end else begin
      rpend_q <= rpend_n;
      raddr_q <= raddr_n;
      stale_q <= stale_n;
      wpend_q <= wpend_n;
      waddr_q <= waddr_n;
      wdata_q <= wdata_n;
      req_q   <= req_n;
      we_q    <= we_n;
      addr_q  <= addr_n;
      buf_q   <= buf_n;
    end
  end

  assign rd_pend   = rpend_q;
  assign wr_pend   = wpend_q;
  assign rd_buf    = buf_q;
  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  // R7: an unanswered request holds its address, direction and data
  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !mem_ack) |=> (req_q && $stable(addr_q) && $stable(we_q) && $stable(wdata_q)));

  // R7: the request is withdrawn right after it is acknowledged
  p_req_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && mem_ack) |=> !req_q);

  // R6: a request is outstanding only while a pending flag is up
  p_req_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (rpend_q || wpend_q));

  // R9: with both kinds pending, the write is the one on the bus
  p_wr_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rpend_q && wpend_q) |-> (req_q && we_q));

  // R10: a fetch marked for discard is always one still in flight
  p_stale_inflight_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stale_q |-> (req_q && !we_q));
endmodule

// File: rtl/pmem_window.sv
module pmem_window #(
  parameter int AW = 9,
  parameter int DW = 12,
  parameter int HW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    hst_addr,
  input  logic          hst_wr,
  input  logic [HW-1:0] hst_wdata,
  input  logic          hst_rd,
  output logic [HW-1:0] hst_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  logic          rst_sn;
  logic          rd_pend, wr_pend;
  logic [DW-1:0] rd_buf;
  logic          rd_kick, wr_kick;
  logic [AW-1:0] rd_kick_addr, wr_kick_addr;
  logic [DW-1:0] wr_kick_data;

  pmw_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sn)
  );

  pmw_regif #(.AW(AW), .DW(DW), .HW(HW)) u_regif (
    .clk          (clk),
    .rst_n        (rst_sn),
    .hst_addr     (hst_addr),
    .hst_wr       (hst_wr),
    .hst_wdata    (hst_wdata),
    .hst_rd       (hst_rd),
    .hst_rdata    (hst_rdata),
    .rd_pend      (rd_pend),
    .wr_pend      (wr_pend),
    .rd_buf       (rd_buf),
    .rd_kick      (rd_kick),
    .rd_kick_addr (rd_kick_addr),
    .wr_kick      (wr_kick),
    .wr_kick_addr (wr_kick_addr),
    .wr_kick_data (wr_kick_data)
  );

  pmw_xfer #(.AW(AW), .DW(DW)) u_xfer (
    .clk          (clk),
    .rst_n        (rst_sn),
    .rd_kick      (rd_kick),
    .rd_kick_addr (rd_kick_addr),
    .wr_kick      (wr_kick),
    .wr_kick_addr (wr_kick_addr),
    .wr_kick_data (wr_kick_data),
    .rd_pend      (rd_pend),
    .wr_pend      (wr_pend),
    .rd_buf       (rd_buf),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack),
    .mem_rdata    (mem_rdata)
  );

  // R1: no store traffic while the block is held in reset
  p_idle_in_reset_r1: assert property (@(posedge clk) !rst_sn |-> !mem_req);
endmodule

// File: tb/pmem_window_test.sv
`timescale 1ns/1ps
module pmem_window_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  hst_addr;
  logic        hst_wr;
  logic [15:0] hst_wdata;
  logic        hst_rd;
  logic [15:0] hst_rdata;
  logic        mem_req, mem_we;
  logic [8:0]  mem_addr;
  logic [11:0] mem_wdata;
  logic        mem_ack;
  logic [11:0] mem_rdata;

  int checks = 0;
  int fails  = 0;
  int lat    = 2;
  int cnt    = 0;
  int viol   = 0;
  bit done   = 0;

  logic [11:0] store [512];
  logic        p_req, p_ack, p_we;
  logic [8:0]  p_addr;
  logic [11:0] p_wd;

  always #2 clk = ~clk;

  pmem_window uut (
    .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wr(hst_wr),
    .hst_wdata(hst_wdata), .hst_rd(hst_rd), .hst_rdata(hst_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [11:0] f(int a);
    return 12'((a * 37 + 5) & 12'hFFF);
  endfunction

  // store model with protocol monitor
  always @(negedge clk) begin
    if (p_req && !p_ack) begin
      if (!mem_req) viol++;
      else if (mem_addr !== p_addr || mem_we !== p_we || mem_wdata !== p_wd) viol++;
    end
    if (p_ack && mem_req) viol++;
    p_req  = mem_req;
    p_addr = mem_addr;
    p_we   = mem_we;
    p_wd   = mem_wdata;
    if (mem_ack) begin
      mem_ack = 1'b0;
      cnt = 0;
    end else if (mem_req) begin
      if (cnt >= lat) begin
        mem_ack   = 1'b1;
        mem_rdata = store[mem_addr];
        if (mem_we) store[mem_addr] = mem_wdata;
        cnt = 0;
      end else begin
        cnt++;
      end
    end else begin
      cnt = 0;
    end
    p_ack = mem_ack;
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
    @(negedge clk);
    hst_wr = 1'b0;
  endtask

  task automatic hrd(logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    hst_addr = a; hst_rd = 1'b1;
    #1 v = hst_rdata;
    @(negedge clk);
    hst_rd = 1'b0;
  endtask

  task automatic wait_idle(output bit seen_err);
    logic [15:0] v;
    seen_err = 0;
    for (int i = 0; i < 200; i++) begin
      hrd(2'd0, v);
      if (v[3]) seen_err = 1;
      if (!v[2]) break;
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    bit e;
    hrd(2'd0, v);
    chk("R1 status after reset", v, 16'h0000);
    chk("R1 mem_req after reset", {15'd0, mem_req}, 16'h0000);
    hrd(2'd3, v);
    chk("R1 data after reset", v, 16'h0000);
    wait_idle(e);
  endtask

  task automatic t_prefetch();
    logic [15:0] v;
    bit e;
    lat = 3;
    hwr(2'd1, 16'hFE00 | 16'd10);
    hrd(2'd0, v);
    chk("R6 status during fetch", v, 16'h0006);
    wait_idle(e);
    hrd(2'd3, v);
    chk("R2 first word at loaded pointer", v, {4'h0, f(10)});
    wait_idle(e);
    hrd(2'd3, v);
    chk("R3 next word after data read", v, {4'h0, f(11)});
    wait_idle(e);
    hrd(2'd3, v);
    chk("R3 third word", v, {4'h0, f(12)});
    wait_idle(e);
  endtask

  task automatic t_write();
    logic [15:0] v;
    bit e;
    lat = 2;
    hwr(2'd2, 16'd100);
    hwr(2'd3, 16'hF5A5);
    hrd(2'd0, v);
    chk("R6 status during store", v, 16'h0005);
    wait_idle(e);
    chk("R4 stored word", {4'h0, store[100]}, 16'h05A5);
    hwr(2'd3, 16'h0123);
    wait_idle(e);
    chk("R4 pointer advanced", {4'h0, store[101]}, 16'h0123);
    hwr(2'd1, 16'd100);
    wait_idle(e);
    hrd(2'd3, v);
    chk("R4 read back stored word", v, 16'h05A5);
    wait_idle(e);
  endtask

  task automatic t_wrap();
    logic [15:0] v;
    bit e;
    lat = 1;
    hwr(2'd2, 16'd511);
    hwr(2'd3, 16'h0ABC);
    wait_idle(e);
    hwr(2'd3, 16'h0DEF);
    wait_idle(e);
    chk("R5 word at 511", {4'h0, store[511]}, 16'h0ABC);
    chk("R5 write pointer wrapped to 0", {4'h0, store[0]}, 16'h0DEF);
    hwr(2'd1, 16'd511);
    wait_idle(e);
    hrd(2'd3, v);
    chk("R5 read at 511", v, 16'h0ABC);
    wait_idle(e);
    hrd(2'd3, v);
    chk("R5 read pointer wrapped to 0", v, 16'h0DEF);
    wait_idle(e);
  endtask

  task automatic t_busy();
    logic [15:0] v;
    bit e;
    lat = 20;
    hwr(2'd2, 16'd200);
    hwr(2'd3, 16'h0111);
    hwr(2'd3, 16'h0222);
    wait_idle(e);
    chk("R8 error seen after refused write", {15'd0, e}, 16'h0001);
    hrd(2'd0, v);
    chk("R8 error cleared by status read", v, 16'h0000);
    chk("R8 accepted word stored", {4'h0, store[200]}, 16'h0111);
    chk("R8 refused word not stored", {4'h0, store[201]}, {4'h0, f(201)});
    hwr(2'd3, 16'h0333);
    wait_idle(e);
    chk("R8 write pointer unchanged by refusal", {4'h0, store[201]}, 16'h0333);
    hwr(2'd1, 16'd300);
    hrd(2'd3, v);
    wait_idle(e);
    chk("R8 error after read while busy", {15'd0, e}, 16'h0001);
    hrd(2'd3, v);
    chk("R8 read pointer unchanged by refusal", v, {4'h0, f(300)});
    wait_idle(e);
  endtask

  task automatic t_queue();
    logic [15:0] v;
    bit e;
    lat = 6;
    hwr(2'd2, 16'd50);
    hwr(2'd3, 16'h0321);
    hwr(2'd1, 16'd50);
    hrd(2'd0, v);
    chk("R9 both pending", v, 16'h0007);
    wait_idle(e);
    hrd(2'd3, v);
    chk("R9 fetch after store sees new word", v, 16'h0321);
    wait_idle(e);
  endtask

  task automatic t_replace();
    logic [15:0] v;
    bit e;
    lat = 8;
    hwr(2'd1, 16'd60);
    hwr(2'd1, 16'd70);
    wait_idle(e);
    hrd(2'd3, v);
    chk("R10 reload during fetch", v, {4'h0, f(70)});
    wait_idle(e);
    hwr(2'd1, 16'd80);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      #1;
      if (mem_ack) break;
    end
    hst_addr = 2'd1; hst_wdata = 16'd90; hst_wr = 1'b1;
    @(negedge clk);
    hst_wr = 1'b0;
    wait_idle(e);
    hrd(2'd3, v);
    chk("R10 reload in acknowledge cycle", v, {4'h0, f(90)});
    wait_idle(e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) store[i] = f(i);
    hst_addr = '0; hst_wr = 0; hst_wdata = '0; hst_rd = 0;
    mem_ack = 0; mem_rdata = '0;
    p_req = 0; p_ack = 0; p_we = 0; p_addr = '0; p_wd = '0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_prefetch();
    t_write();
    t_wrap();
    t_busy();
    t_queue();
    t_replace();
    chk("R7 handshake violations", 16'(viol), 16'h0000);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule